// File: doc/BRIEF.md
# Indirection Graph Prefetch Address Generator

This block turns the data carried by a returned prefetch line into the addresses of the next prefetches. Software first programs a small graph into three tables. The node table describes arrays, one entry per array, with a base address, an element count and an element size in bytes. The edge table gives each edge a kind and a destination node. The edge source table names each edge's source node and carries a valid bit.

A fill presents the node it belongs to and two adjacent loaded values, `fill_lo` (the element at i) and `fill_hi` (the element at i+1). The block then scans every edge in ascending edge order. For each valid edge whose source is the filled node, it derives zero or more destination element addresses of the form base + index × size. Each address goes out with its destination node id, which marks the request for a new tracking entry.

A single-valued edge uses `fill_lo` as one index. A ranged edge walks the indices from `fill_lo` up to, but not including, `fill_hi`, at one index per cycle. Consecutive indices that land in the same 64-byte line give only one request. A node with no outgoing edges produces nothing, and that ends the sequence. `busy` is high for the whole walk, and fills that arrive while it is high are dropped.

Top module: `ind_graph_pfgen`

## Requirements
- R1: After reset, `busy` and `pf_valid` are 0 and every edge source entry reads back as 0, which means no edge is valid.
- R2: A configuration write with `cfg_tbl`=0 (node table) stores base in `cfg_wdata[31:0]`, count in `[47:32]` and size in `[55:48]`. With `cfg_tbl`=1 (edge table) it stores the destination node in `[1:0]` and the kind in `[3:2]`. With `cfg_tbl`=2 (source table) it stores the source node in `[1:0]` and the valid bit in `[2]`. `cfg_rdata` returns the same layout for the entry addressed by `cfg_tbl`/`cfg_addr`, without delay.
- R3: A kind-0 (single-valued) edge issues one request with address dst.base + `fill_lo` × dst.size and with `pf_node` set to its destination.
- R4: An index at or above the destination node's count yields no request.
- R5: A kind-1 (ranged) edge visits the indices `fill_lo` .. `fill_hi`−1 in ascending order, one per cycle. It stops at the destination count and gives no requests when `fill_hi` ≤ `fill_lo`.
- R6: Within one ranged walk, an index whose address lies in the same 64-byte line (address bits [31:6]) as the index visited just before it issues no request.
- R7: Edges are served in ascending edge number. An edge is served only when its source entry is valid and names the filled node. Kind 2 (trigger) and kind 3 issue nothing on a fill.
- R8: `busy` rises on the edge that accepts a fill and stays high for EDGES cycles plus, for each served ranged edge, 1 + the number of indices it visits. A node without outgoing edges therefore gives EDGES busy cycles and no requests.
- R9: A fill presented while `busy` is high is ignored and does not change the running walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 2 | Table select: 0 node, 1 edge, 2 edge source |
| cfg_addr | input | 3 | Entry number |
| cfg_wdata | input | 56 | Write data |
| cfg_rdata | output | 56 | Read-back data of the addressed entry |
| fill_valid | input | 1 | Prefetch fill present |
| fill_node | input | 2 | Node the filled data belongs to |
| fill_lo | input | 16 | Loaded value at element i |
| fill_hi | input | 16 | Loaded value at element i+1 |
| busy | output | 1 | Edge walk in progress |
| pf_valid | output | 1 | Prefetch request valid this cycle |
| pf_addr | output | 32 | Prefetch address |
| pf_node | output | 2 | Destination node of the request |

## Verification
A wrong edge pointer, range cursor or stale line register has a visible effect at the ports. It shows as a missing, extra or misordered `pf_addr` within the cycles of the walk it corrupts, or as a `busy` interval of the wrong length, and it is caught when that walk ends. The reference model in the bench keeps its own copy of the programmed tables and predicts the request list and busy length of each fill. Every emitted request is matched against that prediction on the clock where it appears. Fills that are dropped, ranges that are empty or clipped, and nodes with no outgoing edges each get their own walk.

// File: rtl/ind_graph_pfgen.sv
module ind_graph_pfgen #(
  parameter int NODES   = 4,
  parameter int EDGES   = 8,
  parameter int AW      = 32,
  parameter int IW      = 16,
  parameter int SW      = 8,
  parameter int LINE_SH = 6,
  localparam int NB = $clog2(NODES),
  localparam int EB = $clog2(EDGES),
  localparam int CW = AW + IW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_tbl,
  input  logic [EB-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  output logic [CW-1:0] cfg_rdata,
  input  logic          fill_valid,
  input  logic [NB-1:0] fill_node,
  input  logic [IW-1:0] fill_lo,
  input  logic [IW-1:0] fill_hi,
  output logic          busy,
  output logic          pf_valid,
  output logic [AW-1:0] pf_addr,
  output logic [NB-1:0] pf_node
);

  logic [AW-1:0] nbase [NODES];
  logic [IW-1:0] ncnt  [NODES];
  logic [SW-1:0] nsize [NODES];
  logic [1:0]    etype [EDGES];
  logic [NB-1:0] edst  [EDGES];
  logic          ivld  [EDGES];
  logic [NB-1:0] isrc  [EDGES];

  logic          in_rng, first, rng_emit;
  logic [EB-1:0] eidx;
  logic [NB-1:0] src_q;
  logic [IW-1:0] lo_q, hi_q, cur;
  logic [AW-LINE_SH-1:0] last_line;

  wire [NB-1:0] na = cfg_addr[NB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NODES; n++) begin
        nbase[n] <= '0;
        ncnt[n]  <= '0;
        nsize[n] <= '0;
      end
      for (int e = 0; e < EDGES; e++) begin
        etype[e] <= '0;
        edst[e]  <= '0;
        ivld[e]  <= 1'b0;
        isrc[e]  <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_tbl)
        2'd0: begin
          nbase[na] <= cfg_wdata[AW-1:0];
          ncnt[na]  <= cfg_wdata[AW+IW-1:AW];
          nsize[na] <= cfg_wdata[CW-1:AW+IW];
        end
        2'd1: begin
          edst[cfg_addr]  <= cfg_wdata[NB-1:0];
          etype[cfg_addr] <= cfg_wdata[NB+1:NB];
        end
        2'd2: begin
          isrc[cfg_addr] <= cfg_wdata[NB-1:0];
          ivld[cfg_addr] <= cfg_wdata[NB];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_tbl)
      2'd0:    cfg_rdata = {nsize[na], ncnt[na], nbase[na]};
      2'd1:    cfg_rdata = CW'({etype[cfg_addr], edst[cfg_addr]});
      2'd2:    cfg_rdata = CW'({ivld[cfg_addr], isrc[cfg_addr]});
      default: cfg_rdata = '0;
    endcase
  end

  wire          hit    = ivld[eidx] && (isrc[eidx] == src_q);
  wire [NB-1:0] dst    = edst[eidx];
  wire [IW-1:0] idx    = in_rng ? cur : lo_q;
  wire [AW-1:0] addr   = nbase[dst] + AW'(idx) * AW'(nsize[dst]);
  wire          in_cnt = idx < ncnt[dst];
  wire          last_e = (eidx == EB'(EDGES - 1));
  wire          rng_go = (cur < hi_q) && in_cnt;
  wire [AW-LINE_SH-1:0] line = addr[AW-1:LINE_SH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      in_rng    <= 1'b0;
      first     <= 1'b0;
      rng_emit  <= 1'b0;
      eidx      <= '0;
      src_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      cur       <= '0;
      last_line <= '0;
      pf_valid  <= 1'b0;
      pf_addr   <= '0;
      pf_node   <= '0;
    end else begin
      pf_valid <= 1'b0;
      rng_emit <= 1'b0;
      if (!busy) begin
        if (fill_valid) begin
          busy   <= 1'b1;
          eidx   <= '0;
          in_rng <= 1'b0;
          src_q  <= fill_node;
          lo_q   <= fill_lo;
          hi_q   <= fill_hi;
        end
      end else if (!in_rng) begin
        if (hit && etype[eidx] == 2'd1) begin
          in_rng <= 1'b1;
          cur    <= lo_q;
          first  <= 1'b1;
        end else begin
          if (hit && etype[eidx] == 2'd0 && in_cnt) begin
            pf_valid <= 1'b1;
            pf_addr  <= addr;
            pf_node  <= dst;
          end
          if (last_e) busy <= 1'b0;
          else        eidx <= eidx + 1'b1;
        end
      end else if (rng_go) begin
        if (first || line != last_line) begin
          pf_valid <= 1'b1;
          rng_emit <= 1'b1;
          pf_addr  <= addr;
          pf_node  <= dst;
        end
        last_line <= line;
        first     <= 1'b0;
        cur       <= cur + 1'b1;
      end else begin
        in_rng <= 1'b0;
        if (last_e) busy <= 1'b0;
        else        eidx <= eidx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pfgen_chk.sv
module pfgen_chk #(
  parameter int AW = 32,
  parameter int NB = 2,
  parameter int LINE_SH = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fill_valid,
  input logic          busy,
  input logic          pf_valid,
  input logic [AW-1:0] pf_addr,
  input logic          rng_emit,
  input logic [NB-1:0] src_q
);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fill_valid));

  // R8
  emit_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(busy));

  // R6
  line_collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && rng_emit && $past(pf_valid && rng_emit)) |->
      ((pf_addr >> LINE_SH) != ($past(pf_addr) >> LINE_SH)));

  // R9
  fill_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(src_q));

endmodule

bind ind_graph_pfgen pfgen_chk #(.AW(AW), .NB(NB), .LINE_SH(LINE_SH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .busy(busy),
  .pf_valid(pf_valid), .pf_addr(pf_addr), .rng_emit(rng_emit), .src_q(src_q)
);

// File: tb/sim_ind_graph_pfgen.sv
module sim_ind_graph_pfgen;
  localparam int NODES = 4, EDGES = 8, AW = 32, IW = 16, SW = 8, LSH = 6;
  localparam int CW = AW + IW + SW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_tbl = '0;
  logic [2:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0, cfg_rdata;
  logic fill_valid = 1'b0;
  logic [1:0] fill_node = '0;
  logic [IW-1:0] fill_lo = '0, fill_hi = '0;
  logic busy, pf_valid;
  logic [AW-1:0] pf_addr;
  logic [1:0] pf_node;

  always #10 clk = ~clk;

  ind_graph_pfgen u0 (.*);

  int checks = 0, errors = 0;
  int busy_cnt = 0;
  bit running = 0;
  string tag = "";
  logic [AW-1:0] q_addr[$];
  int q_node[$];

  int sb_base[NODES], sb_cnt[NODES], sb_size[NODES];
  int sb_type[EDGES], sb_dst[EDGES], sb_src[EDGES], sb_vld[EDGES];

  task automatic chk(input bit ok, input string t, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (busy) busy_cnt++;
      if (pf_valid) begin
        if (q_addr.size() == 0) chk(0, {tag, " unexpected request"}, pf_addr, 0);
        else begin
          logic [AW-1:0] ea;
          int en;
          ea = q_addr.pop_front();
          en = q_node.pop_front();
          chk(pf_addr == ea && int'(pf_node) == en, {tag, " request"},
              {pf_node, pf_addr}, {en[1:0], ea});
        end
      end
    end
  end

  task automatic wr_node(input int n, input int base, input int cnt, input int size);
    sb_base[n] = base; sb_cnt[n] = cnt; sb_size[n] = size;
    @(negedge clk);
    cfg_we = 1; cfg_tbl = 0; cfg_addr = 3'(n);
    cfg_wdata = {SW'(size), IW'(cnt), AW'(base)};
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_edge(input int e, input int src, input int vld, input int typ, input int dst);
    sb_type[e] = typ; sb_dst[e] = dst; sb_src[e] = src; sb_vld[e] = vld;
    @(negedge clk);
    cfg_we = 1; cfg_tbl = 1; cfg_addr = 3'(e);
    cfg_wdata = CW'({typ[1:0], dst[1:0]});
    @(negedge clk);
    cfg_tbl = 2; cfg_wdata = CW'({vld[0], src[1:0]});
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input int tbl, input int a, input logic [CW-1:0] exp, input string t);
    cfg_tbl = 2'(tbl); cfg_addr = 3'(a);
    #1;
    chk(cfg_rdata == exp, t, cfg_rdata, exp);
  endtask

  task automatic do_fill(input int node, input int lo, input int hi, input bit inject, input string t);
    int steps;
    int guard;
    steps = 0;
    tag = t;
    for (int e = 0; e < EDGES; e++) begin
      steps++;
      if (sb_vld[e] != 0 && sb_src[e] == node) begin
        int d;
        d = sb_dst[e];
        if (sb_type[e] == 0) begin
          if (lo < sb_cnt[d]) begin
            q_addr.push_back(AW'(sb_base[d] + lo * sb_size[d]));
            q_node.push_back(d);
          end
        end else if (sb_type[e] == 1) begin
          longint last;
          bit fst;
          fst = 1; last = 0;
          steps++;
          for (int j = lo; j < hi && j < sb_cnt[d]; j++) begin
            logic [AW-1:0] a;
            a = AW'(sb_base[d] + j * sb_size[d]);
            steps++;
            if (fst || longint'(a >> LSH) != last) begin
              q_addr.push_back(a);
              q_node.push_back(d);
            end
            last = longint'(a >> LSH);
            fst = 0;
          end
        end
      end
    end
    busy_cnt = 0;
    @(negedge clk);
    fill_valid = 1; fill_node = 2'(node); fill_lo = IW'(lo); fill_hi = IW'(hi);
    @(negedge clk);
    fill_valid = 0;
    if (inject) begin
      @(negedge clk);
      fill_valid = 1; fill_node = 2'd1; fill_lo = 16'd5; fill_hi = 16'd40;
      @(negedge clk);
      fill_valid = 0;
    end
    guard = 0;
    do begin
      @(negedge clk); #1; guard++;
    end while (busy && guard < 5000);
    chk(busy_cnt == steps, {t, " R8 busy length"}, busy_cnt, steps);
    chk(q_addr.size() == 0, {t, " missing requests"}, q_addr.size(), 0);
    q_addr.delete(); q_node.delete();
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < EDGES; e++) begin
      sb_type[e] = 0; sb_dst[e] = 0; sb_src[e] = 0; sb_vld[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && pf_valid == 0, "R1 reset outputs", {busy, pf_valid}, 0);
    rd(2, 4, '0, "R1 source entry cleared");

    wr_node(0, 'h1000, 8, 4);
    wr_node(0, 'h1000, 100, 4);
    wr_node(1, 'h8000, 10, 8);
    wr_node(2, 'h4000, 16, 64);
    wr_node(3, 'hC000, 4, 2);
    wr_edge(0, 0, 1, 2, 0);
    wr_edge(1, 0, 1, 1, 0);
    wr_edge(2, 1, 1, 0, 1);
    wr_edge(3, 0, 1, 0, 2);
    wr_edge(4, 0, 0, 0, 1);
    wr_edge(5, 2, 1, 3, 1);
    rd(0, 1, {8'd8, 16'd10, 32'h8000}, "R2 node readback");
    rd(1, 1, CW'(4'b0100), "R2 edge readback");
    rd(2, 3, CW'(3'b100), "R2 source readback");
    rd(2, 4, CW'(3'b000), "R2 invalid source readback");

    running = 1;
    do_fill(0, 2, 20, 0, "R5 R6 R7 range then single");
    do_fill(1, 5, 0, 0, "R3 single");
    do_fill(1, 10, 0, 0, "R4 at count dropped");
    do_fill(0, 95, 110, 0, "R4 R5 range clipped");
    do_fill(0, 7, 7, 0, "R5 empty range");
    do_fill(3, 1, 2, 0, "R8 no outgoing edges");
    do_fill(2, 1, 3, 0, "R7 reserved kind");
    do_fill(0, 3, 40, 1, "R9 fill while busy");
    wr_node(0, 'h3000, 100, 64);
    do_fill(0, 0, 5, 0, "R6 every element new line");
    running = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule